// File: doc/BRIEF.md
# Fall-through bubble FIFO register

This block is an elastic first-in first-out store built as a chain of stages rather than as a memory with read and write pointers. Each stage holds one data word and a marker bit that is 1 when the stage is filled. A filled stage whose downstream neighbour is empty hands its word on. Words therefore ripple one stage per clock toward the output end, and vacancies bubble back toward the input end. The readiness flags come straight from the markers of the first and last stages.

The producer raises `shift_in` while `in_ready` is high. The word on `din` is captured into the input stage and stays there until the strobe returns low. The consumer reads `dq` while `out_ready` is high, then pulses `shift_out`. The falling edge of that strobe releases the output stage. Both strobes are sampled on `clk`, and edges are found by comparing each sampled strobe with the controller state that remembers its last level. `rst` is an asynchronous master reset. It empties every stage and leaves the data registers untouched. `hiz` models tri-stated outputs.

Input controller states: `IN_IDLE` (strobe seen low), `IN_PEND` (strobe high while the input stage is occupied), `IN_HOLD` (word captured, waiting for the strobe to drop). Transitions: IDLE→HOLD when the strobe is high and the input stage is free. IDLE→PEND when the strobe is high and the stage is occupied. PEND→HOLD when the stage frees. PEND→IDLE when the strobe drops first. HOLD→IDLE when the strobe drops. Output controller states: `OUT_LOW` and `OUT_HIGH` track the sampled release strobe. OUT_LOW→OUT_HIGH happens on a high sample. OUT_HIGH→OUT_LOW happens on a low sample, and that transition is the release event.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst` is high, with or without a clock edge, `in_ready` is 1 and `out_ready` is 0. The word on `dq` is the same as before reset.
- R2: Every accepted word is delivered exactly once on `dq`, in the order of acceptance, under any interleaving of loads and releases.
- R3: `in_ready` is 0 whenever the input stage is occupied. This covers the two clock edges after a load and the whole time 16 words are stored.
- R4: Within two clock edges of a falling `shift_out` while `out_ready` is 1, `out_ready` goes to 0. It becomes 1 again only if a stored word remains.
- R5: Once the store is empty, `dq` keeps showing the last word released.
- R6: A shift-in strobe that rises and falls while the input stage stays occupied is ignored. No word is added, and the stored words come out unchanged.
- R7: A shift-in strobe held high while the store is full loads its word exactly once, as soon as a release frees the input stage.
- R8: A shift-in strobe held high through reset loads its word after `rst` is released.
- R9: A captured word stays in the input stage, with `out_ready` at 0 on an otherwise empty store, for as long as `shift_in` stays high. Changes on `din` during that time do not alter the word.
- R10: With `hiz` at 1, `q_drive` is 0 and `dq` is high impedance. With `hiz` at 0, `q_drive` is 1 and `dq` drives the output stage word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which strobes are sampled |
| rst | input | 1 | Asynchronous master reset, active high |
| shift_in | input | 1 | Load strobe, acts on its rising edge |
| din | input | WIDTH | Word to load |
| shift_out | input | 1 | Release strobe, acts on its falling edge |
| hiz | input | 1 | 1 puts the data outputs in high impedance |
| in_ready | output | 1 | Input stage empty |
| out_ready | output | 1 | Output stage holds a valid word |
| dq | output | WIDTH | Output stage word (tri-state model) |
| q_drive | output | 1 | 1 while `dq` is driven |

## Verification
The bench uses the default build of 4-bit words and 16 stages. This small depth lets a test fill the store completely many times. It can therefore reach the full-store cases: an ignored strobe, a strobe held high until a release, and in-ready staying low. A seeded random mix of loads and releases at every occupancy from empty to full runs against a queue model.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_PEND = 2'd1,
        IN_HOLD = 2'd2
    } in_state_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;
endpackage

// File: rtl/bfifo_in_ctrl.sv
module bfifo_in_ctrl
    import bfifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic first_free,
    output logic load,
    output logic holding
);
    logic      strobe_q;
    in_state_e state_q;
    in_state_e state_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            strobe_q <= 1'b0;
            state_q  <= IN_IDLE;
        end else begin
            strobe_q <= strobe;
            state_q  <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_IDLE: if (strobe_q) state_d = first_free ? IN_HOLD : IN_PEND;
            IN_PEND: if (!strobe_q) state_d = IN_IDLE;
                     else if (first_free) state_d = IN_HOLD;
            IN_HOLD: if (!strobe_q) state_d = IN_IDLE;
            default: state_d = IN_IDLE;
        endcase
    end

    always_comb begin
        load    = (state_q != IN_HOLD) && strobe_q && first_free;
        holding = (state_q == IN_HOLD);
    end

    // R6: a pending request that loses its strobe never loads
    assert_pend_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == IN_PEND && !strobe_q) |=> !holding);
endmodule

// File: rtl/bfifo_out_ctrl.sv
module bfifo_out_ctrl
    import bfifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic release_ev
);
    logic       strobe_q;
    out_state_e state_q;
    out_state_e state_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            strobe_q <= 1'b0;
            state_q  <= OUT_LOW;
        end else begin
            strobe_q <= strobe;
            state_q  <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW:  if (strobe_q) state_d = OUT_HIGH;
            OUT_HIGH: if (!strobe_q) state_d = OUT_LOW;
            default:  state_d = OUT_LOW;
        endcase
    end

    always_comb begin
        release_ev = (state_q == OUT_HIGH) && !strobe_q;
    end
endmodule

// File: rtl/bfifo_chain.sv
module bfifo_chain #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             hold_first,
    input  logic             pop,
    output logic [DEPTH-1:0] markers,
    output logic [WIDTH-1:0] first_word,
    output logic [WIDTH-1:0] last_word
);
    localparam int LAST = DEPTH - 1;

    logic [WIDTH-1:0] word_q [DEPTH];
    logic [DEPTH-1:0] take;
    logic [DEPTH-1:0] give;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             mark_r;
        logic [WIDTH-1:0] word_r;

        if (i == 0) begin : g_head
            assign take[i] = load;
            always_ff @(posedge clk) begin
                if (take[i]) word_r <= load_word;
            end
        end else begin : g_body
            assign take[i] = markers[i-1] & ~markers[i] & ~(hold_first & (i == 1));
            always_ff @(posedge clk) begin
                if (take[i]) word_r <= word_q[i-1];
            end
        end

        if (i == LAST) begin : g_tail
            assign give[i] = pop & markers[i];
        end else begin : g_link
            assign give[i] = take[i+1];
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst)          mark_r <= 1'b0;
            else if (take[i]) mark_r <= 1'b1;
            else if (give[i]) mark_r <= 1'b0;
        end

        assign markers[i] = mark_r;
        assign word_q[i]  = word_r;
    end

    assign first_word = word_q[0];
    assign last_word  = word_q[LAST];
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_out,
    input  logic             hiz,
    output logic             in_ready,
    output logic             out_ready,
    output logic [WIDTH-1:0] dq,
    output logic             q_drive
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             load;
    logic             holding;
    logic             release_ev;
    logic [DEPTH-1:0] markers;
    logic [WIDTH-1:0] first_word;
    logic [WIDTH-1:0] last_word;
    logic [CW:0]      occ;

    bfifo_in_ctrl i_in (
        .clk        (clk),
        .rst        (rst),
        .strobe     (shift_in),
        .first_free (~markers[0]),
        .load       (load),
        .holding    (holding)
    );

    bfifo_out_ctrl i_out (
        .clk        (clk),
        .rst        (rst),
        .strobe     (shift_out),
        .release_ev (release_ev)
    );

    bfifo_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chain (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_word  (din),
        .hold_first (holding),
        .pop        (release_ev),
        .markers    (markers),
        .first_word (first_word),
        .last_word  (last_word)
    );

    assign in_ready  = ~markers[0];
    assign out_ready = markers[DEPTH-1];
    assign dq        = hiz ? 'z : last_word;
    assign q_drive   = ~hiz;

    always_comb occ = (CW + 1)'($countones(markers));

    // R3: a captured word blocks the input flag
    assert_busy_flag_R3: assert property (@(posedge clk) disable iff (rst)
        holding |-> !in_ready);

    // R4: a release of a valid word drops the output flag next cycle
    assert_release_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (release_ev && out_ready) |=> !out_ready);

    // R5: an empty output stage keeps its word
    assert_keep_last_R5: assert property (@(posedge clk) disable iff (rst)
        (!out_ready && $past(!out_ready)) |-> $stable(last_word));

    // R9: the held input word is never disturbed
    assert_hold_word_R9: assert property (@(posedge clk) disable iff (rst)
        (holding && $past(holding)) |-> $stable(first_word));

    // R2: a load stores the input word
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (first_word == $past(din)));

    // R2: occupancy changes by at most one word per clock
    assert_conserve_R2: assert property (@(posedge clk) disable iff (rst)
        (occ <= $past(occ) + 1'b1) && (occ + 1'b1 >= $past(occ)));
endmodule

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;
    localparam int W = 4;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         shift_in;
    logic [W-1:0] din;
    logic         shift_out;
    logic         hiz;
    wire          in_ready;
    wire          out_ready;
    wire  [W-1:0] dq;
    wire          q_drive;

    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;
    logic [W-1:0] model[$];
    logic [W-1:0] last_out;

    always #10 clk = ~clk;

    bubble_fifo #(.WIDTH(W), .DEPTH(D)) i_bubble_fifo (
        .clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
        .shift_out(shift_out), .hiz(hiz), .in_ready(in_ready),
        .out_ready(out_ready), .dq(dq), .q_drive(q_drive)
    );

    function automatic bit exp_out_ready();
        return model.size() > 0;
    endfunction

    function automatic bit exp_in_free();
        return model.size() < D;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_in(input logic v, input string tag);
        for (int k = 0; k < 200 && in_ready !== v; k++) @(negedge clk);
        check(in_ready === v, tag, int'(in_ready), int'(v));
    endtask

    task automatic wait_out(input logic v, input string tag);
        for (int k = 0; k < 200 && out_ready !== v; k++) @(negedge clk);
        check(out_ready === v, tag, int'(out_ready), int'(v));
    endtask

    task automatic push(input logic [W-1:0] d);
        wait_in(1'b1, "R3");
        din = d;
        shift_in = 1'b1;
        wait_in(1'b0, "R3");
        shift_in = 1'b0;
        model.push_back(d);
        @(negedge clk);
    endtask

    task automatic pop(input string tag);
        logic [W-1:0] e;
        wait_out(1'b1, "R4");
        e = model.pop_front();
        check(dq === e, tag, int'(dq), int'(e));
        last_out = e;
        shift_out = 1'b1;
        idle(2);
        shift_out = 1'b0;
        idle(2);
        check(out_ready === 1'b0, "R4", int'(out_ready), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd2024));
        rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0; hiz = 1'b0; din = '0;
        #1;
        check(in_ready === 1'b1, "R1", int'(in_ready), 1);
        check(out_ready === 1'b0, "R1", int'(out_ready), 0);
        idle(3);
        rst = 1'b0;
        idle(2);

        // R2 short directed run, then R4/R5 on empty
        push(4'h3); push(4'hA); push(4'h5);
        pop("R2"); pop("R2"); pop("R2");
        idle(40);
        check(out_ready === exp_out_ready(), "R4", int'(out_ready), int'(exp_out_ready()));
        check(dq === last_out, "R5", int'(dq), int'(last_out));

        // R10 output enable
        hiz = 1'b1;
        @(negedge clk);
        check(q_drive === 1'b0, "R10", int'(q_drive), 0);
        hiz = 1'b0;
        @(negedge clk);
        check(q_drive === 1'b1, "R10", int'(q_drive), 1);
        check(dq === last_out, "R10", int'(dq), int'(last_out));

        // R3 full store, R6 ignored strobe
        for (int k = 0; k < D; k++) push(W'($urandom));
        idle(40);
        check(in_ready === exp_in_free(), "R3", int'(in_ready), int'(exp_in_free()));
        din = 4'hF; shift_in = 1'b1;
        idle(4);
        shift_in = 1'b0;
        idle(40);
        check(in_ready === 1'b0, "R6", int'(in_ready), 0);
        for (int k = 0; k < D; k++) pop("R6");
        idle(40);
        check(out_ready === 1'b0, "R6", int'(out_ready), 0);

        // R7 strobe held high while full
        for (int k = 0; k < D; k++) push(W'(k));
        held = 4'h9; din = held; shift_in = 1'b1;
        idle(20);
        check(in_ready === 1'b0, "R7", int'(in_ready), 0);
        pop("R7");
        idle(80);
        check(in_ready === 1'b0, "R7", int'(in_ready), 0);
        shift_in = 1'b0;
        model.push_back(held);
        for (int k = 0; k < D; k++) pop("R7");
        idle(40);
        check(out_ready === 1'b0, "R7", int'(out_ready), 0);

        // R9 word held in input stage while strobe high
        held = 4'hC; din = held; shift_in = 1'b1;
        wait_in(1'b0, "R9");
        din = 4'h2;
        idle(40);
        check(out_ready === 1'b0, "R9", int'(out_ready), 0);
        shift_in = 1'b0;
        model.push_back(held);
        pop("R9");

        // R1 reset keeps dq and sets the flags
        push(4'h6); push(4'h7);
        wait_out(1'b1, "R4");
        held = dq;
        @(negedge clk);
        rst = 1'b1;
        #1;
        check(in_ready === 1'b1, "R1", int'(in_ready), 1);
        check(out_ready === 1'b0, "R1", int'(out_ready), 0);
        check(dq === held, "R1", int'(dq), int'(held));
        model.delete();
        last_out = held;

        // R8 strobe held through reset
        held = 4'hB; din = held; shift_in = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(6);
        check(in_ready === 1'b0, "R8", int'(in_ready), 0);
        shift_in = 1'b0;
        model.push_back(held);
        pop("R8");

        // R2 seeded random mix
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 2 == 0 && model.size() < D) || model.size() == 0)
                push(W'($urandom));
            else
                pop("R2");
        end
        while (model.size() > 0) pop("R2");
        idle(40);
        check(out_ready === 1'b0, "R5", int'(out_ready), 0);
        check(dq === last_out, "R5", int'(dq), int'(last_out));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule